// File: doc/BRIEF.md
# Streaming Softmax Normalizer

This block turns one vector of signed fixed-point scores into a vector of probabilities. Scores enter one per cycle on a valid/ready stream. Each score is a signed value with 8 integer bits and 8 fraction bits, so the encoding is `value * 256` in two's complement. Probabilities leave on a valid/last stream. Each is an unsigned 16-bit fraction, so the encoding is `p * 65536`. Because 1.0 cannot be represented in this format, it saturates at 0xFFFF.

The work is done in three phases over a single vector.

- **Load.** The scores are stored and the largest one is tracked.
- **Exponentiate.** The stored scores are replayed with the largest subtracted from each. Each difference is exponentiated, and the result is stored a second time while being added into a running total.
- **Normalize.** A bit-serial restoring divider forms the reciprocal of the total once. Each stored exponential is then multiplied by that reciprocal and emitted.

Only one vector is in flight at a time. The input side stays closed until the output phase of the current vector has drained.

Top module: `softmax_stream`

## Requirements
- R1: Out of reset `in_ready` is 1 and `out_valid` is 0. `in_ready` goes low on the edge that accepts the 32nd score of a vector. It stays low until the cycle in which that vector's last probability is presented, and it is high again in that cycle. Scores held on the input while `in_ready` is low are not consumed.
- R2: A vector is exactly 32 accepted scores; bubbles (`in_valid` low) between them are allowed. Exactly 32 probabilities follow, in the same order as the scores. `out_last` is 1 only with the 32nd of them.
- R3: The first score of a vector sets the running maximum, and each later, strictly larger score replaces it. Every exponential is therefore taken of a non-positive argument. The outputs do not change when a common offset is added to every score: a vector of 32 equal scores at -100.0 yields 2048 (1/32) in every position.
- R4: The exponential of (score − maximum) is an unsigned 16-bit fraction. An argument of 0 gives 0xFFFF, and results below 2^-16 flush to 0. One score 20.0 above all the others therefore produces 0xFFFF in its own position and 0 elsewhere.
- R5: The running total of the exponentials has 6 integer and 16 fraction bits. It does not wrap, even when all 32 exponentials are at full scale, and it is never less than one full-scale exponential.
- R6: Each probability is within 128 LSB of the real-valued softmax of the quantized scores, with the real value rounded to 1/65536 and capped at 0xFFFF. The 32 probabilities of a vector add up to a value in [65472, 65536].
- R7: The reciprocal is `floor(2^40 / total)`, computed by restoring division at one quotient bit per cycle (41 bits, MSB first). The first probability of a vector is presented 77 cycles after the edge that accepted its last score. This is 32 replay reads, 41 division steps and 4 register stages. The remaining probabilities follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Score present on `in_data` |
| in_ready | output | 1 | Block accepts a score this cycle |
| in_data | input | 16 | Signed score, 8 fraction bits |
| out_valid | output | 1 | Probability present on `out_data` |
| out_data | output | 16 | Unsigned probability, 16 fraction bits |
| out_last | output | 1 | Marks the final probability of a vector |

## Verification
A maximum that is latched wrongly, or updated on the wrong comparison, has visible consequences at the outputs. Either every exponential underflows to zero, or some arguments turn positive and saturate. Both show in the first probabilities of the vector and in its sum, which drifts far outside the narrow band R6 allows. A corrupted running total or divider step scales the whole output vector by a common factor, so the sum check exposes it as soon as `out_last` arrives. Phase or counter errors show as a first-output cycle that is not exactly 77 after the last acceptance, as a misplaced `out_last`, or as `in_ready` reopening early. All of these are visible within the same vector.

// File: rtl/sm_pkg.sv
package sm_pkg;

  // number formats
  localparam int X_W      = 16;            // signed score, X_FRAC fraction bits
  localparam int X_FRAC   = 8;
  localparam int D_W      = X_W + 1;       // score minus maximum
  localparam int E_W      = 16;            // unsigned fraction, exponentials and probabilities
  localparam int SUM_W    = E_W + 6;       // 6 integer bits
  localparam int R_FRAC   = 24;            // reciprocal fraction bits
  localparam int R_W      = R_FRAC + 1;
  localparam int NUM_EXP  = E_W + R_FRAC;  // dividend is 2^NUM_EXP
  localparam int DIV_W    = NUM_EXP + 1;

  // log2(e) with 14 fraction bits
  localparam int LOG2E_FRAC = 14;
  localparam logic [15:0] LOG2E_Q = 16'd23637;
  localparam int T_FRAC = X_FRAC + LOG2E_FRAC;

  // cubic for 2^f on [0,1), coefficients with 16 fraction bits, summing to 1.0
  localparam logic [15:0] PC1 = 16'd45617;
  localparam logic [15:0] PC2 = 16'd14739;
  localparam logic [15:0] PC3 = 16'd5180;

  typedef enum logic [2:0] {
    PH_LOAD,
    PH_EXP,
    PH_DIVGO,
    PH_DIVWAIT,
    PH_NORM
  } phase_e;

  // 2^f for f in [0,1) as a value with 16 fraction bits, Horner form
  function automatic logic [17:0] pow2_frac(input logic [15:0] f);
    logic [47:0] acc;
    logic [47:0] h2;
    logic [47:0] h1;
    acc = 48'(f) * 48'(PC3);
    h2  = 48'(PC2) + (acc >> 16);
    acc = 48'(f) * h2;
    h1  = 48'(PC1) + (acc >> 16);
    acc = 48'(f) * h1;
    acc = 48'd65536 + (acc >> 16);
    return acc[17:0];
  endfunction

  // e^d for d <= 0 (X_FRAC fraction bits), as a 16-bit fraction saturated at all ones
  function automatic logic [E_W-1:0] exp_nonpos(input logic signed [D_W-1:0] d);
    logic signed [33:0] dx;
    logic signed [33:0] lq;
    logic signed [33:0] t;
    logic signed [33:0] zi;
    logic [33:0] sh;
    logic [17:0] m;
    logic [17:0] r;
    dx = d;
    lq = 34'(LOG2E_Q);
    t  = dx * lq;
    zi = t >>> T_FRAC;
    sh = 34'(-zi);
    m  = pow2_frac(t[T_FRAC-1 -: 16]);
    if (sh > 34'd17) begin
      return '0;
    end
    r = m >> sh[4:0];
    if (r > 18'(2**E_W - 1)) begin
      return '1;
    end
    return r[E_W-1:0];
  endfunction

  // e * r / 2^R_FRAC, saturated to the 16-bit fraction range
  function automatic logic [E_W-1:0] scale_prob(input logic [E_W-1:0] e,
                                                input logic [R_W-1:0] r);
    logic [E_W+R_W-1:0] p;
    p = (E_W+R_W)'(e) * (E_W+R_W)'(r);
    p = p >> R_FRAC;
    if (p > (E_W+R_W)'(2**E_W - 1)) begin
      return '1;
    end
    return p[E_W-1:0];
  endfunction

endpackage

// File: rtl/sm_fifo.sv
module sm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  assign rdata = mem_q[rd_ptr_q];
  assign empty = (count_q == '0);
  assign full  = (count_q == CNT_W'(DEPTH));

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem_q[wr_ptr_q] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= bump(wr_ptr_q);
      if (pop)  rd_ptr_q <= bump(rd_ptr_q);
      if (push && !pop)      count_q <= count_q + 1'b1;
      else if (pop && !push) count_q <= count_q - 1'b1;
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full); // R2
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R2

endmodule

// File: rtl/sm_exp_unit.sv
module sm_exp_unit
  import sm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [X_W-1:0] x,
  input  logic [X_W-1:0] mx,
  output logic           out_vld,
  output logic [E_W-1:0] out_e
);
  logic signed [D_W-1:0] diff_w;

  assign diff_w = $signed({x[X_W-1], x}) - $signed({mx[X_W-1], mx});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_e   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_e <= exp_nonpos(diff_w);
    end
  end

  AST_EXP_ARG_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> (diff_w[D_W-1] || diff_w == '0)); // R3
  AST_EXP_PEAK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && diff_w == '0) |=> (out_vld && out_e == '1)); // R4

endmodule

// File: rtl/sm_recip_div.sv
module sm_recip_div #(
  parameter int N_W = 41,
  parameter int Q_W = 22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] numer,
  input  logic [Q_W-1:0] denom,
  output logic           busy,
  output logic           done,
  output logic [N_W-1:0] quot
);
  localparam int IDX_W = $clog2(N_W);

  logic [N_W-1:0]   num_q;
  logic [Q_W-1:0]   den_q;
  logic [Q_W:0]     rem_q;
  logic [N_W-1:0]   quo_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             done_q;

  logic [Q_W:0]   shifted_w;
  logic [Q_W+1:0] trial_w;
  logic           fits_w;

  assign shifted_w = {rem_q[Q_W-1:0], num_q[idx_q]};
  assign trial_w   = {1'b0, shifted_w} - {2'b00, den_q};
  assign fits_w    = !trial_w[Q_W+1];

  assign busy = busy_q;
  assign done = done_q;
  assign quot = quo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      num_q  <= numer;
      den_q  <= denom;
      rem_q  <= '0;
      quo_q  <= '0;
      idx_q  <= IDX_W'(N_W - 1);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q        <= fits_w ? trial_w[Q_W:0] : shifted_w;
      quo_q[idx_q] <= fits_w;
      if (idx_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        idx_q <= idx_q - 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R7
  AST_DIV_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < {1'b0, den_q})); // R7
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

endmodule

// File: rtl/softmax_stream.sv
module softmax_stream
  import sm_pkg::*;
#(
  parameter int VEC_LEN = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [X_W-1:0] in_data,
  output logic           out_valid,
  output logic [E_W-1:0] out_data,
  output logic           out_last
);
  localparam int CNT_W = $clog2(VEC_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VEC_LEN - 1);
  localparam logic [DIV_W-1:0] ONE_SCALED = DIV_W'(1) << NUM_EXP;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [X_W-1:0]   max_q;
  logic [SUM_W-1:0] sum_q;
  logic [R_W-1:0]   recip_q;
  logic             out_valid_q;
  logic [E_W-1:0]   out_data_q;
  logic             out_last_q;

  // named internal events
  logic             accept_w;
  logic             a_pop_w;
  logic             b_pop_w;
  logic             div_start_w;
  logic             a_empty_w;
  logic             a_full_w;
  logic             b_empty_w;
  logic             b_full_w;
  logic [X_W-1:0]   a_head_w;
  logic [E_W-1:0]   b_head_w;
  logic             e_vld_w;
  logic [E_W-1:0]   e_val_w;
  logic             div_busy_w;
  logic             div_done_w;
  logic [DIV_W-1:0] div_quot_w;
  logic             cnt_at_last_w;

  assign in_ready      = (phase_q == PH_LOAD);
  assign accept_w      = in_valid && in_ready;
  assign a_pop_w       = (phase_q == PH_EXP) && !a_empty_w;
  assign b_pop_w       = (phase_q == PH_NORM) && !b_empty_w;
  assign div_start_w   = (phase_q == PH_DIVGO);
  assign cnt_at_last_w = (cnt_q == CNT_LAST);

  sm_fifo #(.W(X_W), .DEPTH(VEC_LEN)) u_score_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept_w),
    .wdata (in_data),
    .pop   (a_pop_w),
    .rdata (a_head_w),
    .empty (a_empty_w),
    .full  (a_full_w)
  );

  sm_exp_unit u_exp (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (a_pop_w),
    .x       (a_head_w),
    .mx      (max_q),
    .out_vld (e_vld_w),
    .out_e   (e_val_w)
  );

  sm_fifo #(.W(E_W), .DEPTH(VEC_LEN)) u_exp_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (e_vld_w),
    .wdata (e_val_w),
    .pop   (b_pop_w),
    .rdata (b_head_w),
    .empty (b_empty_w),
    .full  (b_full_w)
  );

  sm_recip_div #(.N_W(DIV_W), .Q_W(SUM_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start_w),
    .numer (ONE_SCALED),
    .denom (sum_q),
    .busy  (div_busy_w),
    .done  (div_done_w),
    .quot  (div_quot_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      max_q   <= '0;
      sum_q   <= '0;
      recip_q <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          if (accept_w) begin
            if (cnt_q == '0 || $signed(in_data) > $signed(max_q)) max_q <= in_data;
            if (cnt_at_last_w) begin
              cnt_q   <= '0;
              sum_q   <= '0;
              phase_q <= PH_EXP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_EXP: begin
          if (e_vld_w) begin
            sum_q <= sum_q + SUM_W'(e_val_w);
            if (cnt_at_last_w) begin
              cnt_q   <= '0;
              phase_q <= PH_DIVGO;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_DIVGO: begin
          phase_q <= PH_DIVWAIT;
        end
        PH_DIVWAIT: begin
          if (div_done_w) begin
            recip_q <= div_quot_w[R_W-1:0];
            phase_q <= PH_NORM;
          end
        end
        PH_NORM: begin
          if (b_pop_w) begin
            if (cnt_at_last_w) begin
              cnt_q   <= '0;
              phase_q <= PH_LOAD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_last_q  <= 1'b0;
    end else begin
      out_valid_q <= b_pop_w;
      out_last_q  <= b_pop_w && cnt_at_last_w;
      if (b_pop_w) out_data_q <= scale_prob(b_head_w, recip_q);
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_last  = out_last_q;

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !out_last_q) |-> !in_ready); // R1
  AST_SUM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    div_start_w |-> (sum_q >= SUM_W'(2**E_W - 1))); // R5
  AST_DIV_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOAD || phase_q == PH_NORM) |-> !div_busy_w); // R7
  AST_RECIP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    b_pop_w |-> (recip_q != '0)); // R6

endmodule

// File: tb/tb_softmax_stream.sv
module tb_softmax_stream;
  localparam int N       = 32;
  localparam int TOL     = 128;
  localparam int SUM_TOL = 64;
  localparam int LAT     = N + 41 + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_last;

  softmax_stream dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done_flag = 0;
  real   vec [N];
  int    exp_q [$];
  bit    last_q [$];
  string tag_q [$];
  int    last_acc_cyc = 0;
  bit    busy_win = 0;
  int    ready_err = 0;
  int    vsum = 0;
  bit    first_of_vec = 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: builds real-valued expectations, then streams the scores
  task automatic send_vec(input string tag, input int gap);
    real q [N];
    real mx;
    real s;
    for (int i = 0; i < N; i++) q[i] = real'(int'(vec[i] * 256.0)) / 256.0;
    mx = q[0];
    for (int i = 1; i < N; i++) if (q[i] > mx) mx = q[i];
    s = 0.0;
    for (int i = 0; i < N; i++) s += $exp(q[i] - mx);
    for (int i = 0; i < N; i++) begin
      int e;
      e = int'($exp(q[i] - mx) / s * 65536.0);
      if (e > 65535) e = 65535;
      exp_q.push_back(e);
      last_q.push_back(i == N - 1);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < N; i++) begin
      bit was_ready;
      in_valid = 1'b1;
      in_data  = 16'(int'(vec[i] * 256.0));
      do begin
        was_ready = in_ready;
        @(negedge clk);
      end while (!was_ready);
      if (i == N - 1) begin
        last_acc_cyc = cyc;
        busy_win = 1;
        ready_err = 0;
      end
      in_valid = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (busy_win && !(out_valid && out_last) && in_ready) ready_err++;
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected output", int'(out_data), -1);
        end else begin
          int e;
          bit l;
          string t;
          int d;
          e = exp_q.pop_front();
          l = last_q.pop_front();
          t = tag_q.pop_front();
          d = int'(out_data) - e;
          if (d < 0) d = -d;
          check(d <= TOL, {t, " probability vs real softmax"}, int'(out_data), e);
          check(out_last == l, "R2 out_last position", int'(out_last), int'(l));
          vsum += int'(out_data);
          if (first_of_vec) begin
            check(cyc - last_acc_cyc == LAT, "R7 first-output latency",
                  cyc - last_acc_cyc, LAT);
            first_of_vec = 0;
          end
          if (l) begin
            check(vsum <= 65536 && vsum >= 65536 - SUM_TOL, "R6 vector sum", vsum, 65536);
            check(in_ready == 1'b1, "R1 ready reopens with last output", int'(in_ready), 1);
            check(ready_err == 0, "R1 ready low while vector in flight", ready_err, 0);
            busy_win = 0;
            vsum = 0;
            first_of_vec = 1;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

    // R6: ramp
    for (int i = 0; i < N; i++) vec[i] = -4.0 + 0.25 * i;
    send_vec("R6", 0);

    // R5 and R3: all equal, far below zero; presented back to back to test R1 hold
    for (int i = 0; i < N; i++) vec[i] = -100.0;
    send_vec("R5", 0);

    // R4: one dominant score
    for (int i = 0; i < N; i++) vec[i] = -10.0;
    vec[5] = 10.0;
    send_vec("R4", 0);

    // R3: offset ramp with bubbles between scores (R2)
    for (int i = 0; i < N; i++) vec[i] = 46.0 + 0.25 * i;
    send_vec("R3", 2);

    // R3: smallest first, maximum in the middle
    for (int i = 0; i < N; i++) vec[i] = 1.5 - 0.375 * ((i > 20) ? (i - 20) : (20 - i));
    send_vec("R3", 0);

    // R4: extremes of the input range
    for (int i = 0; i < N; i++) vec[i] = (i % 2 == 1) ? 127.0 : -128.0;
    vec[3] = 126.5;
    send_vec("R4", 1);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R2 no extra output", int'(out_valid), 0);
    finish_run();
  end

endmodule